// File: doc/BRIEF.md
# Serial Write Framer with CRC Append

This block turns bytes handed over by a processor into a serial bit stream for a magnetic disk head. Each bit strobe from the drive timing logic pulls one bit out of a shift register, least-significant bit first. The shift register refills from a one-byte data latch at every byte boundary, and a byte-ready flag (and optionally an interrupt) tells software to supply the next byte.

Until software arms the transfer, the block writes zeros, which lay down the inter-block gap. Once software asks for the checksum, the running reflected CRC-16 of the written data is swapped into the shift register one byte at a time at the next byte boundaries. The checksum phase ends on its own when the remaining CRC value reaches zero. Software steers the block through a control byte in which bit 2 selects read mode, bit 4 requests the CRC append, bit 6 arms the transfer and bit 7 enables the interrupt.

Top module: `disk_write_framer`

## Requirements
- R1: A control write that takes bit 6 from 0 to 1 arms the transfer. If bit 2 of the same write is 0 (write mode), it also reloads the shift register from the latch, resets the bit index to 0, sets byte_rdy, clears the CRC to 0 and enables CRC accumulation. With bit 2 set, byte_rdy is left unchanged.
- R2: While the transfer is not armed, every accepted strobe drives wr_bit to 0. A control write with bit 6 at 0 disarms the transfer.
- R3: While armed, each accepted strobe drives wr_bit with the shift-register bit at the current index, starting from bit 0 (LSB first). The index then advances.
- R4: While accumulation is enabled, each written bit advances the CRC one step with the reflected polynomial 0x8408. The initial value is 0, and a bit whose XOR with CRC bit 0 is 1 folds the polynomial in after a right shift.
- R5: After the eighth bit of a byte, the shift register reloads from the latch and byte_rdy is set. irq is set as well if control bit 7 is 1. Any control write clears irq.
- R6: At a byte boundary with control bit 4 set, the shift register takes the low byte of the CRC instead of the latch. The CRC is then shifted right by 8 and accumulation stops, so the CRC goes out low byte first.
- R7: If the CRC is zero at such a boundary, control bit 4 is cleared and the latch is reset to 0. Later boundaries reload from the latch again.
- R8: A write to the data latch clears byte_rdy.
- R9: With write_protect high, strobes neither change wr_bit nor advance the bit position, and wr_en is low.
- R10: wr_en is high only in write mode (control bit 2 clear), with write_protect and xfer_reset low. Strobes in read mode or during transfer reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe, one per bit cell |
| latch_we | input | 1 | Data latch write enable |
| latch_wdata | input | DATA_W | Byte to be written next |
| ctrl_we | input | 1 | Control byte write enable |
| ctrl_wdata | input | 8 | Control byte (bit 2 read mode, bit 4 CRC append, bit 6 arm, bit 7 irq enable) |
| write_protect | input | 1 | Disk is write protected |
| xfer_reset | input | 1 | Head is being returned; no transfer |
| wr_bit | output | 1 | Serial bit to the head |
| wr_en | output | 1 | Write gate to the head |
| byte_rdy | output | 1 | Byte consumed, latch may be refilled |
| irq | output | 1 | Byte-boundary interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit byte, a 16-bit CRC and polynomial 0x8408. These values make a CRC exactly two bytes long, so the full append sequence can be followed bit by bit. That sequence is low byte, high byte, the zero-remainder boundary that clears the request and resets the latch, and the return to latch reloads. The bench predicts the checksum bytes with its own bit-serial CRC and walks through gap zeros, write-protect stalls, read-mode arming and the interrupt enable.

// File: rtl/wf_pkg.sv
package wf_pkg;
    localparam int CTL_W       = 8;
    localparam int CTL_READ    = 2;
    localparam int CTL_CRC     = 4;
    localparam int CTL_ARM     = 6;
    localparam int CTL_IRQ_EN  = 7;
    typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/wf_crc_step.sv
module wf_crc_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h8408
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] shifted;
    always_comb begin
        shifted = crc_i >> 1;
        crc_o   = (crc_i[0] ^ bit_i) ? (shifted ^ POLY) : shifted;
    end
endmodule

// File: rtl/wf_bit_pick.sv
module wf_bit_pick #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     word_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    always_comb bit_o = word_i[idx_i];
endmodule

// File: rtl/disk_write_framer.sv
module disk_write_framer
    import wf_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                CRC_W    = 16,
    parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              latch_we,
    input  logic [DATA_W-1:0] latch_wdata,
    input  logic              ctrl_we,
    input  logic [CTL_W-1:0]  ctrl_wdata,
    input  logic              write_protect,
    input  logic              xfer_reset,
    output logic              wr_bit,
    output logic              wr_en,
    output logic              byte_rdy,
    output logic              irq
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] latch;
        logic [IDX_W-1:0]  idx;
        logic [CRC_W-1:0]  crc;
        logic              crc_on;
        logic              armed;
        ctl_t              ctl;
        logic              rdy;
        logic              irq;
        logic              wbit;
    } fr_state_t;

    fr_state_t s_d, s_q;

    logic             cur_bit;
    logic [CRC_W-1:0] crc_step;
    logic             armed_w;
    ctl_t             ctl_w;

    wf_bit_pick #(.W(DATA_W), .IDX_W(IDX_W)) u_pick (
        .word_i (s_q.shift),
        .idx_i  (s_q.idx),
        .bit_o  (cur_bit)
    );

    wf_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (s_q.crc),
        .bit_i  (cur_bit),
        .crc_o  (crc_step)
    );

    always_comb begin
        logic             move;
        logic [CRC_W-1:0] crc_adv;
        s_d     = s_q;
        move    = bit_stb && !s_q.ctl[CTL_READ] && !xfer_reset && !write_protect;
        crc_adv = s_q.crc_on ? crc_step : s_q.crc;

        if (move) begin
            if (!s_q.armed) begin
                s_d.wbit = 1'b0;
            end else begin
                s_d.wbit = cur_bit;
                s_d.crc  = crc_adv;
                if (s_q.idx == IDX_LAST) begin
                    s_d.idx   = '0;
                    s_d.shift = s_q.latch;
                    s_d.rdy   = 1'b1;
                    if (s_q.ctl[CTL_IRQ_EN]) s_d.irq = 1'b1;
                    if (s_q.ctl[CTL_CRC]) begin
                        if (crc_adv == '0) begin
                            s_d.ctl[CTL_CRC] = 1'b0;
                            s_d.latch        = '0;
                        end
                        s_d.shift  = crc_adv[DATA_W-1:0];
                        s_d.crc    = crc_adv >> DATA_W;
                        s_d.crc_on = 1'b0;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end

        if (latch_we) begin
            s_d.latch = latch_wdata;
            s_d.rdy   = 1'b0;
        end

        if (ctrl_we) begin
            s_d.irq = 1'b0;
            if (!ctrl_wdata[CTL_ARM]) begin
                s_d.armed = 1'b0;
            end else if (!s_q.ctl[CTL_ARM]) begin
                s_d.armed = 1'b1;
                if (!ctrl_wdata[CTL_READ]) begin
                    s_d.idx    = '0;
                    s_d.shift  = s_d.latch;
                    s_d.rdy    = 1'b1;
                    s_d.crc    = '0;
                    s_d.crc_on = 1'b1;
                end
            end
            s_d.ctl = ctrl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_bit   = s_q.wbit;
    assign byte_rdy = s_q.rdy;
    assign irq      = s_q.irq;
    assign wr_en    = !s_q.ctl[CTL_READ] && !write_protect && !xfer_reset;
    assign armed_w  = s_q.armed;
    assign ctl_w    = s_q.ctl;
endmodule

// File: rtl/wf_checker.sv
module wf_checker
    import wf_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic latch_we,
    input logic ctrl_we,
    input ctl_t ctrl_wdata,
    input logic write_protect,
    input logic wr_bit,
    input logic wr_en,
    input logic byte_rdy,
    input logic irq,
    input logic armed,
    input ctl_t ctl_state
);
    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && wr_en && !armed && !ctrl_we) |=> !wr_bit);

    assert_arm_sets_rdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[CTL_ARM] && !ctrl_wdata[CTL_READ] && !ctl_state[CTL_ARM])
        |=> byte_rdy);

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctl_state[CTL_IRQ_EN]));

    assert_ctrl_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !irq);

    assert_latch_clears_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_we && !ctrl_we) |=> !byte_rdy);

    assert_protect_holds_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (write_protect && bit_stb && !ctrl_we) |=> $stable(wr_bit));
endmodule

bind disk_write_framer wf_checker u_wf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_stb       (bit_stb),
    .latch_we      (latch_we),
    .ctrl_we       (ctrl_we),
    .ctrl_wdata    (ctrl_wdata),
    .write_protect (write_protect),
    .wr_bit        (wr_bit),
    .wr_en         (wr_en),
    .byte_rdy      (byte_rdy),
    .irq           (irq),
    .armed         (armed_w),
    .ctl_state     (ctl_w)
);

// File: tb/tb_disk_write_framer.sv
module tb_disk_write_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       latch_we = 1'b0;
    logic [7:0] latch_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       write_protect = 1'b0;
    logic       xfer_reset = 1'b0;
    logic       wr_bit, wr_en, byte_rdy, irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    typedef struct {
        logic  b;
        string req;
    } exp_t;
    exp_t exp_q[$];
    logic stb_seen = 1'b0;

    always #10 clk = ~clk;

    disk_write_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
        .latch_we(latch_we), .latch_wdata(latch_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .write_protect(write_protect), .xfer_reset(xfer_reset),
        .wr_bit(wr_bit), .wr_en(wr_en), .byte_rdy(byte_rdy), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        stb_seen <= bit_stb;
    end

    // monitor: compares each strobed bit against the scoreboard
    always @(negedge clk) begin
        if (stb_seen && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(wr_bit, e.b, e.req);
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic strobe(input logic push, input logic b, input string req);
        @(negedge clk);
        bit_stb = 1'b1;
        if (push) begin
            exp_t e;
            e.b = b;
            e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input string req);
        for (int i = 0; i < 8; i++) strobe(1'b1, v[i], req);
    endtask

    task automatic latch_wr(input logic [7:0] v);
        @(negedge clk);
        latch_we = 1'b1;
        latch_wdata = v;
        @(negedge clk);
        latch_we = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // drives the CRC append phase and expects the zero-remainder byte last
    task automatic send_crc(input logic [15:0] start);
        logic [15:0] c;
        logic fin;
        c = start;
        for (int k = 0; k < 4; k++) begin
            send_byte(c[7:0], "R6");
            fin = (c == 16'h0000);
            c = c >> 8;
            if (fin) break;
        end
    endtask

    initial begin
        logic [15:0] crc;
        logic held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_bit, 1'b0, "R10 reset wr_bit");
        check(byte_rdy, 1'b0, "R10 reset byte_rdy");
        check(irq, 1'b0, "R10 reset irq");
        check(wr_en, 1'b1, "R10 reset wr_en");

        latch_wr(8'hFF);
        for (int i = 0; i < 6; i++) strobe(1'b1, 1'b0, "R2 gap zero");

        ctrl_wr(8'h44);                       // read mode + arm
        check(wr_en, 1'b0, "R10 read mode");
        check(byte_rdy, 1'b0, "R1 read-mode arm");
        strobe(1'b0, 1'b0, "");
        ctrl_wr(8'h00);
        check(wr_en, 1'b1, "R10 write mode");
        strobe(1'b1, 1'b0, "R2 disarmed");

        latch_wr(8'hA5);
        ctrl_wr(8'hC0);                       // arm + irq enable
        check(byte_rdy, 1'b1, "R1 arm sets byte_rdy");
        check(irq, 1'b0, "R1 no irq on arm");
        latch_wr(8'h3C);
        check(byte_rdy, 1'b0, "R8 latch clears byte_rdy");
        send_byte(8'hA5, "R3");
        check(byte_rdy, 1'b1, "R5 byte_rdy at boundary");
        check(irq, 1'b1, "R5 irq at boundary");
        ctrl_wr(8'hD0);                       // request CRC append
        check(irq, 1'b0, "R5 ctrl write clears irq");
        send_byte(8'h3C, "R5 reload");
        crc = crc_byte(crc_byte(16'h0000, 8'hA5), 8'h3C);   // R4
        send_crc(crc);
        latch_wr(8'h5A);
        send_byte(8'h00, "R7 latch reset");
        send_byte(8'h5A, "R7 crc request cleared");

        write_protect = 1'b1;
        @(negedge clk);
        check(wr_en, 1'b0, "R9 protect wr_en");
        held = wr_bit;
        for (int i = 0; i < 5; i++) strobe(1'b0, 1'b0, "");
        check(wr_bit, held, "R9 protect holds bit");
        write_protect = 1'b0;
        send_byte(8'h5A, "R9 no advance");

        xfer_reset = 1'b1;
        @(negedge clk);
        check(wr_en, 1'b0, "R10 xfer_reset");
        strobe(1'b0, 1'b0, "");
        xfer_reset = 1'b0;

        ctrl_wr(8'h40);                       // irq disabled
        latch_wr(8'h5A);
        send_byte(8'h5A, "R10 after xfer_reset");
        check(byte_rdy, 1'b1, "R5 byte_rdy without irq");
        check(irq, 1'b0, "R5 irq disabled");

        ctrl_wr(8'h00);
        for (int i = 0; i < 3; i++) strobe(1'b1, 1'b0, "R2 gap again");
        latch_wr(8'h01);
        ctrl_wr(8'h50);                       // re-arm with CRC request
        send_byte(8'h01, "R4 rearm data");
        send_crc(crc_byte(16'h0000, 8'h01));

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, 1'b1, "R3 scoreboard drained");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule